// File: doc/BRIEF.md
# Half-Rate Third-Order Decimating Filter for a One-Bit Stream

This block turns the one-bit output of a sigma-delta modulator into wide, decimated samples. It applies a third-order cascaded integrator-comb (Sinc3) response. The bits are first grouped into pairs. Each pair of valid input bits forms one filter step, so the integrators run at half the bit rate. The first integrator is a small counter that adds 0, 1 or 2 per step.

The second and third integrators share a single adder. One operand of that adder is always the second integrator. The other operand is selected by a multiplexer:

- In the clock in which a pair completes, the adder takes the third integrator and updates it.
- In the following clock, the adder takes the first integrator and updates the second integrator. The first integrator advances in that same clock.

A comb section samples the third integrator once per decimation period. It takes three cascaded first differences and emits a sample together with a one-cycle valid strobe.

The decimation ratio is given in input bits and is an even number. After reset, or after the effective ratio changes, the first three comb outputs are suppressed while the comb history fills.

Top module: `sinc3_pair_decim`

## Requirements
- R1: Only bits presented with `bit_vld` high count. Each two consecutive valid bits form one step, and the first integrator advances by their sum (0, 1 or 2). Bits with `bit_vld` low leave the result unchanged.
- R2: Let c[k] be the third integrator sampled at decimation event k. Each emitted sample equals c[k] - 3c[k-1] + 3c[k-2] - c[k-3], where c is zero before the first event after reset. In steady state at ratio R, an all-ones stream gives R^3/4, a stream alternating 1,0 gives R^3/8, and an all-zeros stream gives 0.
- R3: All integrator and comb arithmetic wraps modulo 2^W. Integrator overflow during long runs does not disturb the output, which stays at its steady value.
- R4: The second and third integrators are never written in the same clock. Valid bits may arrive on every clock without loss.
- R5: `sample_vld` is a single-cycle pulse. It follows every ratio/2 steps, that is, every `ratio` valid bits.
- R6: The least significant bit of `ratio` is ignored, so an odd ratio acts as the next lower even value. A ratio below 2 acts as 2.
- R7: The first three decimation events after reset, and the first three after a change of the effective ratio, produce no `sample_vld`. A ratio change also restarts the decimation count.
- R8: While in reset, and until the first emitted sample, `sample` is 0 and `sample_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Modulator bit |
| bit_vld | input | 1 | Qualifies `bit_in` for this clock |
| ratio | input | RW | Decimation ratio in input bits (even; LSB ignored) |
| sample | output | W | Filtered, decimated sample (modulo 2^W) |
| sample_vld | output | 1 | One-cycle strobe marking a new `sample` |

## Verification
The bench feeds constant and alternating streams and checks that each settles to the closed-form steady value. A design whose pairing or adder phasing was wrong would instead settle to a different constant or never settle. A long all-ones run drives the integrators through their wrap point. A design without modular comb differences would show a glitch in the output at that point. Bits arriving on every clock, mixed with runs that have gaps in `bit_vld`, expose any design that drops a bit or lets an invalid bit count. Odd, tiny and changed ratios are also exercised. A design that honoured the ratio LSB, did not restart its count, or emitted a sample from a contaminated comb history would produce extra outputs or wrong values against the bench's own half-rate model.

// File: rtl/sinc3_pair_decim.sv
module sinc3_pair_decim #(
  parameter int W  = 30,
  parameter int RW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_in,
  input  logic          bit_vld,
  input  logic [RW-1:0] ratio,
  output logic [W-1:0]  sample,
  output logic          sample_vld
);
  localparam int MW = RW - 1;

  logic          half, first_bit, step_b;
  logic [1:0]    pair_sum;
  logic [W-1:0]  acc1, acc2, acc3;
  logic [MW-1:0] m_q, cnt;
  logic [1:0]    fill;
  logic [W-1:0]  z1, z2, z3;

  wire [MW-1:0] m_eff  = (ratio[RW-1:1] == '0) ? MW'(1) : ratio[RW-1:1];
  wire          step_a = bit_vld & half;
  wire [W-1:0]  opnd   = step_a ? acc3 : acc1;
  wire [W-1:0]  sum    = acc2 + opnd;
  wire          chg    = (m_eff != m_q);
  wire          evt    = step_b && (cnt == m_q - MW'(1)) && !chg;
  wire [W-1:0]  d1     = acc3 - z1;
  wire [W-1:0]  d2     = d1 - z2;
  wire [W-1:0]  d3     = d2 - z3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half      <= 1'b0;
      first_bit <= 1'b0;
      pair_sum  <= '0;
      step_b    <= 1'b0;
    end else begin
      step_b <= step_a;
      if (bit_vld) begin
        half <= ~half;
        if (!half) first_bit <= bit_in;
        else       pair_sum  <= {1'b0, first_bit} + {1'b0, bit_in};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc1 <= '0;
      acc2 <= '0;
      acc3 <= '0;
    end else begin
      if (step_a) acc3 <= sum;
      if (step_b) begin
        acc2 <= sum;
        acc1 <= acc1 + W'(pair_sum);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q        <= MW'(1);
      cnt        <= '0;
      fill       <= '0;
      z1         <= '0;
      z2         <= '0;
      z3         <= '0;
      sample     <= '0;
      sample_vld <= 1'b0;
    end else begin
      sample_vld <= evt && (fill == 2'd3);
      if (chg) begin
        m_q  <= m_eff;
        cnt  <= '0;
        fill <= '0;
      end else if (step_b) begin
        cnt <= evt ? '0 : cnt + MW'(1);
      end
      if (evt) begin
        z1 <= acc3;
        z2 <= d1;
        z3 <= d2;
        if (fill != 2'd3) fill <= fill + 2'd1;
        else              sample <= d3;
      end
    end
  end

  p_share_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_a && step_b));

  p_acc1_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step_b |=> ((acc1 - $past(acc1)) <= W'(2)));

  p_vld_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |=> !sample_vld);

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> !sample_vld);
endmodule

// File: tb/tb_sinc3_pair_decim.sv
module tb_sinc3_pair_decim;
  localparam int W  = 30;
  localparam int RW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bit_in = 1'b0;
  logic          bit_vld = 1'b0;
  logic [RW-1:0] ratio = RW'(8);
  logic [W-1:0]  sample;
  logic          sample_vld;

  sinc3_pair_decim #(.W(W), .RW(RW)) dut (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .ratio(ratio), .sample(sample), .sample_vld(sample_vld));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, n_out = 0;
  bit done = 0;
  logic [W-1:0] last_out;
  logic [W-1:0] expq[$];

  logic         m_half, m_first;
  logic [W-1:0] m1, m2, m3, mz1, mz2, mz3, md1, md2, md3;
  int           m_m, m_cnt, m_fill;

  function automatic int eff(input int r);
    int m = r >> 1;
    return (m == 0) ? 1 : m;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp_v);
    checks++;
    if (got !== exp_v) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", req, got, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && sample_vld) begin
      n_out++;
      last_out = sample;
      if (expq.size() == 0) chk("R7 unexpected sample", sample, '0);
      else chk("R2 sample vs model", sample, expq.pop_front());
    end
  end

  task automatic model_reset();
    m_half = 0; m_first = 0;
    m1 = 0; m2 = 0; m3 = 0; mz1 = 0; mz2 = 0; mz3 = 0;
    m_m = eff(int'(ratio)); m_cnt = 0; m_fill = 0;
    expq.delete();
  endtask

  task automatic do_reset(input int r);
    @(negedge clk);
    rst_n = 0; bit_vld = 0; bit_in = 0; ratio = RW'(r);
    model_reset();
    repeat (3) @(negedge clk);
    chk("R8 reset sample", sample, '0);
    chk("R8 reset valid", W'(sample_vld), '0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    n_out = 0;
  endtask

  task automatic feed(input logic b, input logic v);
    @(negedge clk);
    bit_in = b; bit_vld = v;
    if (v) begin
      if (!m_half) begin
        m_first = b; m_half = 1;
      end else begin
        m_half = 0;
        m3 = m3 + m2; m2 = m2 + m1; m1 = m1 + W'(m_first) + W'(b);
        m_cnt++;
        if (m_cnt == m_m) begin
          m_cnt = 0;
          md1 = m3 - mz1; md2 = md1 - mz2; md3 = md2 - mz3;
          mz1 = m3; mz2 = md1; mz3 = md2;
          if (m_fill < 3) m_fill++;
          else expq.push_back(md3);
        end
      end
    end
  endtask

  task automatic drain();
    repeat (8) feed(1'b0, 1'b0);
    chk("R5 all model samples emitted", W'(expq.size()), '0);
  endtask

  task automatic set_ratio(input int r);
    @(negedge clk);
    bit_vld = 0;
    ratio = RW'(r);
    if (eff(r) != m_m) begin
      m_m = eff(r); m_cnt = 0; m_fill = 0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_ones();
    do_reset(8);
    for (int i = 0; i < 80; i++) feed(1'b1, 1'b1);
    drain();
    chk("R2 all-ones steady value ratio 8", last_out, W'(128));
    chk("R7 output count, 10 events minus 3", W'(n_out), W'(7));
  endtask

  task automatic t_alt_zero();
    do_reset(8);
    for (int i = 0; i < 80; i++) feed(1'(i % 2 == 0), 1'b1);
    drain();
    chk("R2 alternating steady value", last_out, W'(64));
    do_reset(8);
    for (int i = 0; i < 48; i++) feed(1'b0, 1'b1);
    drain();
    chk("R2 all-zeros value", last_out, W'(0));
  endtask

  task automatic t_gaps();
    logic [15:0] lf = 16'hACE1;
    do_reset(12);
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      feed(lf[0], lf[3] | lf[7]);
    end
    drain();
    checks++;
    if (n_out < 10) begin
      fails++;
      $display("FAIL R1 gapped stream produced %0d samples, expected at least 10", n_out);
    end
  endtask

  task automatic t_wrap();
    do_reset(8);
    for (int i = 0; i < 4000; i++) feed(1'b1, 1'b1);
    drain();
    chk("R3 value after integrator wrap", last_out, W'(128));
    chk("R4 back-to-back bit count of samples", W'(n_out), W'(497));
  endtask

  task automatic t_ratio();
    do_reset(9);
    for (int i = 0; i < 80; i++) feed(1'b1, 1'b1);
    drain();
    chk("R6 odd ratio 9 acts as 8", last_out, W'(128));
    do_reset(1);
    for (int i = 0; i < 20; i++) feed(1'b1, 1'b1);
    drain();
    chk("R6 ratio 1 acts as 2", last_out, W'(2));
    chk("R6 ratio 1 sample count", W'(n_out), W'(7));
  endtask

  task automatic t_change();
    do_reset(8);
    for (int i = 0; i < 32; i++) feed(1'b1, 1'b1);
    drain();
    chk("R7 samples before change", W'(n_out), W'(1));
    set_ratio(16);
    n_out = 0;
    for (int i = 0; i < 80; i++) feed(1'b1, 1'b1);
    drain();
    chk("R7 samples after change, 5 events minus 3", W'(n_out), W'(2));
    chk("R7 steady value at ratio 16", last_out, W'(1024));
  endtask

  initial begin
    t_ones();
    t_alt_zero();
    t_gaps();
    t_wrap();
    t_ratio();
    t_change();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule